// File: doc/BRIEF.md
# Length-Decoded Serial Register Loader

This block is a three-wire serial control port that loads one of three control registers without any address or steering bits. A host pulls the active-low enable low, clocks data in most significant bit first on rising serial-clock edges, and releases the enable. The number of serial-clock rising edges seen during that window selects what happens when the enable rises: the 8-bit configuration register, the 16-bit feedback divide register or the 15-bit reference divide register is written, or the port performs a device reset. Any other count writes nothing. Each write produces a one-cycle strobe. The strobe for the feedback divide register doubles as the jam-load pulse for the divider counters and phase detectors.

The port runs on a fast system clock. The serial clock, enable and data pins pass through two-flop synchronizers, and the serial clock and enable also go through edge detectors. A serial output echoes each sampled bit one falling serial-clock edge later, so the host can run a wrap-around test or pass a long stream on to a cascaded device. Transfers longer than 32 clocks are treated as pass-through and write nothing locally. The output enable is low whenever the port enable is high.

Top module: `serial_len_loader`

## Requirements
- R1: While the enable is low, each serial-clock rising edge shifts the data pin into the shift register. The first bit sent is the most significant bit, and a register always takes the most recently shifted bits.
- R2: An enable rise after exactly 8 clocks loads the configuration register with the 8 bits sent. It pulses `cfg_wr_o` for one cycle and leaves the divide registers unchanged.
- R3: An enable rise after exactly 16 clocks loads the feedback divide register with the 16 bits sent. It pulses `fdiv_jam_o` for one cycle as the divider jam-load.
- R4: An enable rise after 15 or 24 clocks loads the reference divide register with the last 15 bits shifted in and pulses `rdiv_wr_o`. In a 24-clock transfer the first 9 bits have no effect.
- R5: An enable rise after 9 to 13 clocks, inclusive, pulses `dev_rst_o` and returns all three registers to their defaults.
- R6: An enable rise after any other count from 0 to 32 writes no register and pulses no strobe.
- R7: A transfer longer than 32 clocks writes nothing locally. During it the serial output keeps echoing every bit.
- R8: No register changes except in the cycle its strobe, or `dev_rst_o`, is high. In particular, no register changes while bits are being shifted.
- R9: While the enable is low, each serial-clock falling edge sets `sdo_o` to the bit sampled on the preceding rising edge. `sdo_oe_o` is high only while the enable is low.
- R10: While the enable is high, the bit counter stays at zero and serial-clock edges are ignored. Clock pulses given with the enable high do not change the count of the next transfer.
- R11: Defaults after power-on reset and after a device reset are as follows. The configuration register is 8'h10: bits 4:2 are 100 and bits 7, 6, 5, 1 and 0 are 0. Both divide registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sck_i | input | 1 | Serial clock pin |
| sen_n_i | input | 1 | Active-low port enable pin |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data echo |
| sdo_oe_o | output | 1 | Output enable for the three-state serial output |
| cfg_o | output | 8 | Configuration register |
| fdiv_o | output | 16 | Feedback divide register |
| rdiv_o | output | 15 | Reference divide register |
| cfg_wr_o | output | 1 | Configuration write strobe |
| fdiv_jam_o | output | 1 | Feedback write strobe and divider jam-load |
| rdiv_wr_o | output | 1 | Reference write strobe |
| dev_rst_o | output | 1 | Device reset strobe from the short-count pattern |

## Verification
The bench aims at the length boundaries on either side of each decoded count: 7, 8, 9, 13, 14, 15, 16, 17, 23, 24, 32, 33 and a zero-length enable pulse. An off-by-one counter shows up as a missing write or as a write to the wrong register. A decoder that mishandles the reset window shows up as registers that do not return to 8'h10/0, or as a spurious reset on counts 14 or 8.

Clock pulses given with the enable high catch a counter that is not held clear, because the 8-clock write that follows would decode as a reset. Echo checks on every bit, including in cascade-length streams, catch a serial output that is sampled on the wrong edge or taken from the wrong stage. Random lengths and data, compared against a bench model, expose any leak of don't-care leading bits into the reference register.

// File: rtl/sll_pkg.sv
package sll_pkg;
  localparam int CFG_W      = 8;
  localparam int FDIV_W     = 16;
  localparam int RDIV_W     = 15;
  localparam int LOCAL_MAX  = 32;
  localparam int CNT_W      = $clog2(LOCAL_MAX + 2);
  localparam int SR_W       = 24;

  localparam logic [CNT_W-1:0] LEN_CFG    = CNT_W'(8);
  localparam logic [CNT_W-1:0] LEN_FDIV   = CNT_W'(16);
  localparam logic [CNT_W-1:0] LEN_RDIV_S = CNT_W'(15);
  localparam logic [CNT_W-1:0] LEN_RDIV_L = CNT_W'(24);
  localparam logic [CNT_W-1:0] LEN_RST_LO = CNT_W'(9);
  localparam logic [CNT_W-1:0] LEN_RST_HI = CNT_W'(13);
  localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(LOCAL_MAX + 1);

  localparam logic [CFG_W-1:0]  CFG_DEFAULT  = 8'b0001_0000;
  localparam logic [FDIV_W-1:0] FDIV_DEFAULT = '0;
  localparam logic [RDIV_W-1:0] RDIV_DEFAULT = '0;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_CFG  = 3'd1,
    TGT_FDIV = 3'd2,
    TGT_RDIV = 3'd3,
    TGT_RST  = 3'd4
  } tgt_e;

  // Maps a transfer length to its action; saturated counts fall to none.
  function automatic tgt_e decode_len(input logic [CNT_W-1:0] n);
    if (n == LEN_CFG)                          return TGT_CFG;
    else if (n == LEN_FDIV)                    return TGT_FDIV;
    else if (n == LEN_RDIV_S || n == LEN_RDIV_L) return TGT_RDIV;
    else if (n >= LEN_RST_LO && n <= LEN_RST_HI) return TGT_RST;
    else                                       return TGT_NONE;
  endfunction
endpackage

// File: rtl/sll_sync.sv
module sll_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RST_VAL;
    else        chain_q[0] <= d_i;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sll_edge.sv
module sll_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/sll_shift.sv
module sll_shift
  import sll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             sen_rise_i,
  input  logic             sen_fall_i,
  input  logic             sdi_i,
  output logic [SR_W-1:0]  sr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sdo_o,
  output logic             oe_o
);
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sdo_q;
  logic             oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else if (idle_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (sck_rise_i) begin
        sr_q <= {sr_q[SR_W-2:0], sdi_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (sck_fall_i) sdo_q <= sr_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          oe_q <= 1'b0;
    else if (sen_rise_i) oe_q <= 1'b0;
    else if (sen_fall_i) oe_q <= 1'b1;
  end

  assign sr_o  = sr_q;
  assign cnt_o = cnt_q;
  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/sll_regs.sv
module sll_regs
  import sll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tgt_e              tgt_i,
  input  logic [SR_W-1:0]   sr_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [FDIV_W-1:0] fdiv_o,
  output logic [RDIV_W-1:0] rdiv_o,
  output logic              cfg_wr_o,
  output logic              fdiv_wr_o,
  output logic              rdiv_wr_o,
  output logic              rst_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o     <= CFG_DEFAULT;
      fdiv_o    <= FDIV_DEFAULT;
      rdiv_o    <= RDIV_DEFAULT;
      cfg_wr_o  <= 1'b0;
      fdiv_wr_o <= 1'b0;
      rdiv_wr_o <= 1'b0;
      rst_o     <= 1'b0;
    end else begin
      cfg_wr_o  <= 1'b0;
      fdiv_wr_o <= 1'b0;
      rdiv_wr_o <= 1'b0;
      rst_o     <= 1'b0;
      case (tgt_i)
        TGT_CFG: begin
          cfg_o    <= sr_i[CFG_W-1:0];
          cfg_wr_o <= 1'b1;
        end
        TGT_FDIV: begin
          fdiv_o    <= sr_i[FDIV_W-1:0];
          fdiv_wr_o <= 1'b1;
        end
        TGT_RDIV: begin
          rdiv_o    <= sr_i[RDIV_W-1:0];
          rdiv_wr_o <= 1'b1;
        end
        TGT_RST: begin
          cfg_o  <= CFG_DEFAULT;
          fdiv_o <= FDIV_DEFAULT;
          rdiv_o <= RDIV_DEFAULT;
          rst_o  <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_len_loader.sv
module serial_len_loader
  import sll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sen_n_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [FDIV_W-1:0] fdiv_o,
  output logic [RDIV_W-1:0] rdiv_o,
  output logic              cfg_wr_o,
  output logic              fdiv_jam_o,
  output logic              rdiv_wr_o,
  output logic              dev_rst_o
);
  // Synchronized pins and the events derived from them.
  logic sck_s, sen_s, sdi_s;
  logic sck_rise, sck_fall, sen_rise, sen_fall;
  logic [SR_W-1:0]  shift_word;
  logic [CNT_W-1:0] bit_cnt;
  tgt_e             commit_tgt;

  sll_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));
  sll_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_sen (
    .clk(clk), .rst_n(rst_n), .d_i(sen_n_i), .q_o(sen_s));
  sll_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d_i(sdi_i), .q_o(sdi_s));

  sll_edge #(.RST_VAL(1'b0)) u_edge_sck (
    .clk(clk), .rst_n(rst_n), .d_i(sck_s), .rise_o(sck_rise), .fall_o(sck_fall));
  sll_edge #(.RST_VAL(1'b1)) u_edge_sen (
    .clk(clk), .rst_n(rst_n), .d_i(sen_s), .rise_o(sen_rise), .fall_o(sen_fall));

  sll_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (sen_s),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .sen_rise_i(sen_rise),
    .sen_fall_i(sen_fall),
    .sdi_i     (sdi_s),
    .sr_o      (shift_word),
    .cnt_o     (bit_cnt),
    .sdo_o     (sdo_o),
    .oe_o      (sdo_oe_o)
  );

  // The count still holds the transfer length in the enable-rise cycle.
  assign commit_tgt = sen_rise ? decode_len(bit_cnt) : TGT_NONE;

  sll_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .tgt_i    (commit_tgt),
    .sr_i     (shift_word),
    .cfg_o    (cfg_o),
    .fdiv_o   (fdiv_o),
    .rdiv_o   (rdiv_o),
    .cfg_wr_o (cfg_wr_o),
    .fdiv_wr_o(fdiv_jam_o),
    .rdiv_wr_o(rdiv_wr_o),
    .rst_o    (dev_rst_o)
  );
endmodule

// File: rtl/sll_checker.sv
module sll_checker
  import sll_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sen_s,
  input logic              sen_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              sdo_oe_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic [FDIV_W-1:0] fdiv_o,
  input logic [RDIV_W-1:0] rdiv_o,
  input logic              cfg_wr_o,
  input logic              fdiv_jam_o,
  input logic              rdiv_wr_o,
  input logic              dev_rst_o
);
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_o && !dev_rst_o) |-> $stable(cfg_o)); // R8
  AST_FDIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fdiv_jam_o && !dev_rst_o) |-> $stable(fdiv_o)); // R8
  AST_RDIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdiv_wr_o && !dev_rst_o) |-> $stable(rdiv_o)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_wr_o, fdiv_jam_o, rdiv_wr_o, dev_rst_o})); // R6
  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_o || fdiv_jam_o || rdiv_wr_o || dev_rst_o) |-> $past(sen_rise)); // R2
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sen_s |=> (bit_cnt == '0)); // R10
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sen_rise |=> !sdo_oe_o); // R9
  AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |-> (cfg_o == CFG_DEFAULT && fdiv_o == FDIV_DEFAULT && rdiv_o == RDIV_DEFAULT)); // R5
endmodule

bind serial_len_loader sll_checker u_sll_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sen_s     (sen_s),
  .sen_rise  (sen_rise),
  .bit_cnt   (bit_cnt),
  .sdo_oe_o  (sdo_oe_o),
  .cfg_o     (cfg_o),
  .fdiv_o    (fdiv_o),
  .rdiv_o    (rdiv_o),
  .cfg_wr_o  (cfg_wr_o),
  .fdiv_jam_o(fdiv_jam_o),
  .rdiv_wr_o (rdiv_wr_o),
  .dev_rst_o (dev_rst_o)
);

// File: tb/tb_serial_len_loader.sv
module tb_serial_len_loader;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sen_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [7:0]  cfg;
  logic [15:0] fdiv;
  logic [14:0] rdiv;
  logic cfg_wr, fdiv_jam, rdiv_wr, dev_rst;

  int checks = 0;
  int errors = 0;
  int n_cfg = 0, n_fdiv = 0, n_rdiv = 0, n_rst = 0;
  logic [7:0]  m_cfg  = 8'h10;
  logic [15:0] m_fdiv = '0;
  logic [14:0] m_rdiv = '0;

  always #2 clk = ~clk;

  serial_len_loader dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sen_n_i(sen_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg), .fdiv_o(fdiv), .rdiv_o(rdiv),
    .cfg_wr_o(cfg_wr), .fdiv_jam_o(fdiv_jam), .rdiv_wr_o(rdiv_wr), .dev_rst_o(dev_rst));

  always @(posedge clk) begin
    if (cfg_wr)   n_cfg++;
    if (fdiv_jam) n_fdiv++;
    if (rdiv_wr)  n_rdiv++;
    if (dev_rst)  n_rst++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Bench model of what a transfer of length n leaves behind.
  function automatic int kind_of(input int n);
    if (n == 8) return 1;
    if (n == 16) return 2;
    if (n == 15 || n == 24) return 3;
    if (n >= 9 && n <= 13) return 4;
    return 0;
  endfunction

  task automatic xfer(input logic [63:0] bits, input int n, input string req);
    int c0, f0, r0, d0, k;
    c0 = n_cfg; f0 = n_fdiv; r0 = n_rdiv; d0 = n_rst;
    sen_n = 1'b0;
    wait_clk(HALF);
    check({req, " oe low-enable"}, {31'd0, sdo_oe}, 32'd1);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
      // R9/R7 echo of the bit just sampled
      check({req, " R9 sdo echo"}, {31'd0, sdo}, {31'd0, bits[i]});
      // R8 registers untouched mid-transfer
      check({req, " R8 cfg stable"}, {24'd0, cfg}, {24'd0, m_cfg});
    end
    sen_n = 1'b1;
    wait_clk(10);
    k = kind_of(n);
    case (k)
      1: m_cfg = bits[7:0];
      2: m_fdiv = bits[15:0];
      3: m_rdiv = bits[14:0];
      4: begin m_cfg = 8'h10; m_fdiv = '0; m_rdiv = '0; end
      default: ;
    endcase
    check({req, " cfg"},  {24'd0, cfg},  {24'd0, m_cfg});
    check({req, " fdiv"}, {16'd0, fdiv}, {16'd0, m_fdiv});
    check({req, " rdiv"}, {17'd0, rdiv}, {17'd0, m_rdiv});
    check({req, " R2 cfg strobe"},  n_cfg - c0,  (k == 1) ? 1 : 0);
    check({req, " R3 jam strobe"},  n_fdiv - f0, (k == 2) ? 1 : 0);
    check({req, " R4 rdiv strobe"}, n_rdiv - r0, (k == 3) ? 1 : 0);
    check({req, " R5 reset strobe"}, n_rst - d0, (k == 4) ? 1 : 0);
    check({req, " R9 oe off"}, {31'd0, sdo_oe}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R11 power-on defaults
    check("R11 cfg default", {24'd0, cfg}, 32'h10);
    check("R11 fdiv default", {16'd0, fdiv}, 32'd0);
    check("R11 rdiv default", {17'd0, rdiv}, 32'd0);
    check("R9 oe idle", {31'd0, sdo_oe}, 32'd0);

    xfer(64'hA5, 8, "R2 cfg write");
    xfer(64'hBEEF, 16, "R3 fdiv write");
    xfer(64'h5A5A, 15, "R4 rdiv short");
    xfer(64'hFF_F123, 24, "R4 rdiv long, R1 leading bits ignored");
    xfer(64'h1FF, 9, "R5 reset 9");
    xfer(64'h3C, 8, "R2 cfg again");
    xfer(64'h1ABC, 13, "R5 reset 13");
    xfer(64'h7F, 7, "R6 count 7");
    xfer(64'h3FFF, 14, "R6 count 14");
    xfer(64'h1FFFF, 17, "R6 count 17");
    xfer(64'h7FFFFF, 23, "R6 count 23");
    xfer(64'hFFFF_FFFF, 32, "R6 count 32");
    xfer(64'h0, 0, "R6 count 0");
    xfer(64'h1_2345_6789, 33, "R7 cascade 33");
    xfer(64'hDEAD_BEEF_CAFE, 48, "R7 cascade 48");

    // R10: clock pulses with the enable high must not count
    for (int p = 0; p < 3; p++) begin
      sck = 1'b1; wait_clk(HALF);
      sck = 1'b0; wait_clk(HALF);
    end
    xfer(64'hC3, 8, "R10 idle clocks ignored");

    // R1: random lengths and data against the model
    for (int t = 0; t < 60; t++) begin
      int sel, len;
      logic [63:0] d;
      d = {$urandom(), $urandom()};
      sel = $urandom_range(0, 5);
      case (sel)
        0: len = 8;
        1: len = 16;
        2: len = 15;
        3: len = 24;
        4: len = $urandom_range(9, 13);
        default: len = $urandom_range(0, 40);
      endcase
      xfer(d, len, "R1 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule